// File: doc/BRIEF.md
# Network Interrupt Packet Receiver

This block sits on the receive side of a ring network node. Each cycle it may see one incoming packet: a command strobe, a 2-bit interrupt level, the node ID of the sender, the node ID of the destination and a 32-bit user word. A packet whose strobe is set and whose destination is either this node or the all-nodes value is accepted. The block then queues the pair {sender ID, user word} in the queue for that packet's level. There are four levels, and each level has its own 127-entry queue.

Each level drives an interrupt line. The line is high while its queue holds entries and its enable bit is set. Local software services an interrupt by popping the queue for that level through a simple read port. The popped entry appears one cycle after the pop request. If a packet arrives while its queue is full, the packet is discarded and a sticky overflow flag is set for that level. Software clears the flag by writing a clear bit. The block assumes that earlier data traffic has already been ordered ahead of the interrupt packets upstream.

Top module: `net_irq_rx`

## Requirements
- R1: A packet with `pkt_strobe_i`=1 and `pkt_dst_i` equal to `node_id_i` is stored at the tail of the queue selected by `pkt_level_i` (0..3). The entry is visible after the next rising clock edge.
- R2: A packet with `pkt_strobe_i`=1 and `pkt_dst_i`=8'hFF is accepted on every node, whatever the value of `node_id_i`.
- R3: A packet with `pkt_strobe_i`=0, or with a destination that is neither `node_id_i` nor 8'hFF, changes no queue and sets no overflow flag.
- R4: Each queue holds up to 127 entries and returns them in arrival order. The popped entry is presented as {`pop_src_o`, `pop_data_o`}.
- R5: After every clock edge, `irq_o[l]` equals `irq_en_i[l]` AND (queue l not empty).
- R6: A pop (`pop_i`=1 with `pop_level_i`=l) on a non-empty queue sets `pop_valid_o`=1 in the next cycle, with the head entry, and removes that entry. A pop on an empty queue gives `pop_valid_o`=0. In cycles without a pop, `pop_valid_o` is 0.
- R7: An accepted packet whose queue already holds 127 entries is dropped and sets `ovf_o[l]`. The flag holds until a cycle with `ovf_clr_i[l]`=1. If a drop and a clear happen in the same cycle, the flag is set.
- R8: While `rst_ni` is low, all queues are empty, and `irq_o`, `ovf_o` and `pop_valid_o` are 0.
- R9: The levels are independent of one another. A push and a pop on the same level in the same cycle both take effect. The full test for the push uses the fill level before that cycle.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| node_id_i | input | 8 | ID of this node |
| pkt_strobe_i | input | 1 | Interrupt command strobe |
| pkt_level_i | input | 2 | Interrupt level of the packet |
| pkt_src_i | input | 8 | Sender node ID |
| pkt_dst_i | input | 8 | Destination node ID (8'hFF means all nodes) |
| pkt_data_i | input | 32 | User word |
| irq_en_i | input | 4 | Enable bit for each level |
| pop_i | input | 1 | Pop request |
| pop_level_i | input | 2 | Level to pop |
| ovf_clr_i | input | 4 | Clear bit for each overflow flag |
| pop_valid_o | output | 1 | Popped entry valid |
| pop_src_o | output | 8 | Sender ID of the popped entry |
| pop_data_o | output | 32 | User word of the popped entry |
| irq_o | output | 4 | Interrupt line for each level |
| ovf_o | output | 4 | Sticky overflow flag for each level |

## Verification
The bench fills one queue to exactly 127 entries and then sends one more packet. A design with an off-by-one error in the full test would either keep a 128th entry or drop the 127th, and the overflow flag would be set too early or not at all. Broadcast packets and packets addressed to other nodes are mixed with packets addressed to this node. A filter that ignores the all-nodes value, or that accepts a foreign ID, shows up as a wrong interrupt level or a wrong pop result. A push and a pop on the same level in the same cycle, and a pop on an empty queue, expose errors in counter or pointer updates. Toggling the enable bits checks that an interrupt line follows the enable bit without losing queued entries.

// File: rtl/net_irq_pkg.sv
package net_irq_pkg;
  localparam int NODE_W = 8;
  localparam int DATA_W = 32;
  localparam logic [NODE_W-1:0] BCAST_ID = '1;

  typedef struct packed {
    logic [NODE_W-1:0] src;
    logic [DATA_W-1:0] data;
  } irq_entry_t;
endpackage

// File: rtl/pkt_filter.sv
module pkt_filter
  import net_irq_pkg::*;
#(
  parameter int LEVELS = 4,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [LVL_W-1:0]  level_i,
  input  logic [NODE_W-1:0] dst_i,
  input  logic [NODE_W-1:0] node_id_i,
  output logic [LEVELS-1:0] push_o
);
  logic hit;
  assign hit = strobe_i && ((dst_i == node_id_i) || (dst_i == BCAST_ID));

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    assign push_o[l] = hit && (level_i == LVL_W'(l));
  end

  assert_push_needs_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|push_o) |-> strobe_i);
  assert_push_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(push_o));
endmodule

// File: rtl/irq_fifo.sv
module irq_fifo
  import net_irq_pkg::*;
#(
  parameter int DEPTH = 127,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  irq_entry_t wdata_i,
  input  logic       pop_i,
  output irq_entry_t head_o,
  output logic       empty_o,
  output logic       full_o
);
  irq_entry_t       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  assign empty_o = (count == '0);
  assign full_o  = (count == CNT_W'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] inc(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= inc(wr_ptr);
      if (do_pop)  rd_ptr <= inc(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end

  assert_count_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= CNT_W'(DEPTH));
  assert_full_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !pop_i |=> full_o);
  assert_empty_pop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && !push_i |=> empty_o);
endmodule

// File: rtl/net_irq_rx.sv
module net_irq_rx
  import net_irq_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int DEPTH  = 127,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        node_id_i,
  input  logic              pkt_strobe_i,
  input  logic [LVL_W-1:0]  pkt_level_i,
  input  logic [7:0]        pkt_src_i,
  input  logic [7:0]        pkt_dst_i,
  input  logic [31:0]       pkt_data_i,
  input  logic [LEVELS-1:0] irq_en_i,
  input  logic              pop_i,
  input  logic [LVL_W-1:0]  pop_level_i,
  input  logic [LEVELS-1:0] ovf_clr_i,
  output logic              pop_valid_o,
  output logic [7:0]        pop_src_o,
  output logic [31:0]       pop_data_o,
  output logic [LEVELS-1:0] irq_o,
  output logic [LEVELS-1:0] ovf_o
);
  logic [LEVELS-1:0] push, pop_sel, empty, full, drop;
  irq_entry_t        head [LEVELS];
  irq_entry_t        wentry, rd_sel;

  assign wentry = '{src: pkt_src_i, data: pkt_data_i};

  pkt_filter #(.LEVELS(LEVELS)) i_filter (
    .clk_i, .rst_ni,
    .strobe_i (pkt_strobe_i),
    .level_i  (pkt_level_i),
    .dst_i    (pkt_dst_i),
    .node_id_i,
    .push_o   (push)
  );

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    assign pop_sel[l] = pop_i && (pop_level_i == LVL_W'(l));
    assign drop[l]    = push[l] && full[l];

    irq_fifo #(.DEPTH(DEPTH)) i_fifo (
      .clk_i, .rst_ni,
      .push_i  (push[l]),
      .wdata_i (wentry),
      .pop_i   (pop_sel[l]),
      .head_o  (head[l]),
      .empty_o (empty[l]),
      .full_o  (full[l])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           ovf_o[l] <= 1'b0;
      else if (drop[l])      ovf_o[l] <= 1'b1;
      else if (ovf_clr_i[l]) ovf_o[l] <= 1'b0;
    end

    assign irq_o[l] = irq_en_i[l] && !empty[l];

    assert_ovf_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_o[l] && !ovf_clr_i[l] |=> ovf_o[l]);
    assert_irq_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[l] |-> irq_en_i[l]);
  end

  assign rd_sel = head[pop_level_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pop_valid_o <= 1'b0;
      pop_src_o   <= '0;
      pop_data_o  <= '0;
    end else begin
      pop_valid_o <= pop_i && !empty[pop_level_i];
      if (pop_i && !empty[pop_level_i]) begin
        pop_src_o  <= rd_sel.src;
        pop_data_o <= rd_sel.data;
      end
    end
  end

  assert_pop_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pop_i |=> !pop_valid_o);
  assert_pop_hit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !empty[pop_level_i] |=> pop_valid_o);
endmodule

// File: tb/test_net_irq_rx.sv
module test_net_irq_rx;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  node_id = 8'h2A;
  logic        strobe = 0;
  logic [1:0]  lvl = 0;
  logic [7:0]  src = 0, dst = 0;
  logic [31:0] data = 0;
  logic [3:0]  en = 0;
  logic        pop = 0;
  logic [1:0]  plvl = 0;
  logic [3:0]  clr = 0;
  logic        pop_valid;
  logic [7:0]  pop_src;
  logic [31:0] pop_data;
  logic [3:0]  irq, ovf;

  int checks = 0, fails = 0;
  logic [39:0] q [4][$];
  logic [3:0]  m_ovf = 0;

  always #10 clk = ~clk;

  net_irq_rx i_net_irq_rx (
    .clk_i(clk), .rst_ni(rst_n), .node_id_i(node_id),
    .pkt_strobe_i(strobe), .pkt_level_i(lvl), .pkt_src_i(src), .pkt_dst_i(dst),
    .pkt_data_i(data), .irq_en_i(en), .pop_i(pop), .pop_level_i(plvl),
    .ovf_clr_i(clr), .pop_valid_o(pop_valid), .pop_src_o(pop_src),
    .pop_data_o(pop_data), .irq_o(irq), .ovf_o(ovf)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_irq();
    logic [3:0] r;
    for (int l = 0; l < 4; l++) r[l] = en[l] && (q[l].size() != 0);
    return r;
  endfunction

  function automatic bit accepts(logic s, logic [7:0] d);
    return s && (d == node_id || d == 8'hFF);
  endfunction

  // called at a negedge; drives one cycle, updates model, checks at next negedge
  task automatic step(input logic s, input logic [1:0] l, input logic [7:0] sr,
                      input logic [7:0] d, input logic [31:0] dt,
                      input logic p, input logic [1:0] pl, input logic [3:0] c);
    bit          e_valid;
    logic [39:0] e_ent;
    int          pre_sz;
    strobe = s; lvl = l; src = sr; dst = d; data = dt; pop = p; plvl = pl; clr = c;
    e_valid = p && (q[pl].size() != 0);
    e_ent = e_valid ? q[pl][0] : '0;
    pre_sz = q[l].size();
    if (e_valid) void'(q[pl].pop_front());
    m_ovf = m_ovf & ~c;
    if (accepts(s, d)) begin
      if (pre_sz < 127) q[l].push_back({sr, dt});
      else m_ovf[l] = 1'b1;
    end
    @(negedge clk);
    chk(pop_valid == e_valid, "R6 pop_valid", 64'(pop_valid), 64'(e_valid));
    if (e_valid) chk({pop_src, pop_data} == e_ent, "R4 popped entry", 64'({pop_src, pop_data}), 64'(e_ent));
    chk(irq == exp_irq(), "R5 irq", 64'(irq), 64'(exp_irq()));
    chk(ovf == m_ovf, "R7 ovf", 64'(ovf), 64'(m_ovf));
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] rd;
    @(negedge clk);
    chk(irq == 0 && ovf == 0 && pop_valid == 0, "R8 reset outputs", 64'({irq, ovf, pop_valid}), 0);
    rst_n = 1;
    en = 4'hF;
    @(negedge clk);

    // R1 direct address
    step(1, 1, 8'h05, 8'h2A, 32'hCAFE0001, 0, 0, 0);
    chk(irq == 4'b0010, "R1 level 1 stored", 64'(irq), 64'h2);
    // R3 ignored packets
    step(1, 0, 8'h06, 8'h2B, 32'h1, 0, 0, 0);
    step(0, 3, 8'h06, 8'h2A, 32'h2, 0, 0, 0);
    chk(irq == 4'b0010, "R3 no store", 64'(irq), 64'h2);
    // R2 broadcast
    node_id = 8'h71;
    step(1, 3, 8'h09, 8'hFF, 32'hB0B0B0B0, 0, 0, 0);
    chk(irq == 4'b1010, "R2 broadcast", 64'(irq), 64'hA);
    node_id = 8'h2A;
    step(0, 0, 0, 0, 0, 1, 1, 0);
    chk(pop_src == 8'h05 && pop_data == 32'hCAFE0001, "R1 popped", 64'({pop_src, pop_data}), 64'h05CAFE0001);
    step(0, 0, 0, 0, 0, 1, 3, 0);
    step(0, 0, 0, 0, 0, 1, 0, 0); // R6 empty pop
    chk(pop_valid == 0, "R6 empty pop", 64'(pop_valid), 0);

    // R4/R7 fill level 2 to the limit and one more
    for (int i = 0; i < 127; i++) step(1, 2, 8'(i), 8'hFF, 32'(i * 3), 0, 0, 0);
    chk(ovf == 0, "R4 127 entries no overflow", 64'(ovf), 0);
    step(1, 2, 8'hEE, 8'h2A, 32'hDEAD, 0, 0, 0);
    chk(ovf == 4'b0100, "R7 overflow set", 64'(ovf), 64'h4);
    // R5 enable masking
    en = 4'h0; idle();
    chk(irq == 0, "R5 masked", 64'(irq), 0);
    en = 4'hF; idle();
    // R9 full queue: push+pop same cycle, push dropped (pre-fill test)
    step(1, 2, 8'hEF, 8'h2A, 32'hBEEF, 1, 2, 4'b0100);
    chk(ovf == 4'b0100, "R7 set beats clear", 64'(ovf), 64'h4);
    step(0, 0, 0, 0, 0, 0, 0, 4'b0100);
    chk(ovf == 0, "R7 cleared", 64'(ovf), 0);
    for (int i = 0; i < 126; i++) step(0, 0, 0, 0, 0, 1, 2, 0);
    chk(irq[2] == 0, "R4 drained", 64'(irq), 0);
    // R9 simultaneous push/pop on one level
    step(1, 0, 8'h11, 8'h2A, 32'h11, 0, 0, 0);
    step(1, 0, 8'h12, 8'h2A, 32'h12, 1, 0, 0);
    chk(pop_valid && pop_src == 8'h11 && irq[0], "R9 push+pop", 64'({pop_valid, pop_src, irq}), 64'h1111);
    step(0, 0, 0, 0, 0, 1, 0, 0);

    // random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 9);
      rd = (r < 5) ? node_id : (r < 7) ? 8'hFF : 8'($urandom);
      if ($urandom_range(0, 49) == 0) en = 4'($urandom);
      step(1'($urandom_range(0, 2) != 0), 2'($urandom), 8'($urandom), rd, $urandom,
           1'($urandom_range(0, 2) == 0), 2'($urandom),
           ($urandom_range(0, 19) == 0) ? 4'($urandom) : 4'h0);
    end
    summary();
  end
endmodule